// File: doc/BRIEF.md
# Configuration Memory Readout Sequencer

This block streams a stored bitstream out of an internal read-only array so that an FPGA can load its configuration. An address counter steps through a region of the array one position at a time. Each step is triggered either by a rising edge on the external configuration clock or by a tick from an internal divider. A mode input selects the output width. In parallel mode a whole byte appears on an 8-bit bus for each step. In serial mode one bit per step appears on bit 0, starting with the most significant bit, and the byte address moves on after eight bits.

The array holds four design revisions. Each revision has its own start address and its own length. A rising edge on the active-low restart input samples the 2-bit revision select and loads the counter with the start of that revision. Three conditions stop the output and hold the counter at the start of the latched revision: chip enable deasserted (standby), the output-enable/reset input low, and an internal power-on sequence that runs after reset. Each output has an enable bit in a separate vector beside its data bit, so a high-impedance state shows up as an enable bit of 0.

Top module: `cfg_rom_reader`

## Requirements
- R1: The counter steps once per step tick only while ce_ni_i is 0, the effective output-enable/reset is 1, restart_ni_i is 1 and, in parallel mode only, busy_i is 0. Otherwise it holds.
- R2: While oe_rst_ni_i is 0, the counter is held at the start address of the latched revision with bit index 0. All data enables are 0, and clk_out_oe_o is 0.
- R3: While ce_ni_i is 1 (standby), the counter is held at the start address of the latched revision. All data enables and clk_out_oe_o are 0.
- R4: At a clock edge where restart_ni_i is 1 and was 0 at the previous edge, rev_sel_i is latched and the counter loads the start address rev_sel_i*16, with bit index 0. That cycle gives no step. The latched revision is 0 after reset.
- R5: In serial mode (par_mode_i=0), only data_oe_o[0] is set. data_o[0] gives the current byte starting at bit 7 and ending at bit 0, and the address advances after the eighth bit. busy_i has no effect in this mode.
- R6: In parallel mode (par_mode_i=1), data_oe_o is 8'hFF and data_o presents one byte per step. The array byte at address a is (a*37+5) mod 256. Any data bit whose enable is 0 reads 0.
- R7: Revision r holds 4+2r bytes. When the counter reaches start+length, it stops stepping and all data enables are 0 until it is reloaded.
- R8: After rst_ni is released, por_drive_o is 1 for exactly 8 clock cycles. During that time the block behaves as if oe_rst_ni_i were 0.
- R9: With clk_sel_i=1, a step tick occurs every 4th clock cycle from an internal divider and cfg_clk_i is ignored. With clk_sel_i=0, each rising edge of cfg_clk_i gives one tick.
- R10: clk_out_o is 1 for one cycle, in the cycle after each step tick, while clk_out_oe_o is 1. clk_out_oe_o is 1 when ce_ni_i is 0 and the effective output-enable/reset is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_clk_i | input | 1 | External configuration clock, sampled by clk_i |
| clk_sel_i | input | 1 | 1: internal divider ticks, 0: cfg_clk_i edges |
| ce_ni_i | input | 1 | Chip enable, active low; 1 puts the block in standby |
| oe_rst_ni_i | input | 1 | Output enable / counter reset, active low |
| restart_ni_i | input | 1 | Restart; a rising edge reloads the counter |
| busy_i | input | 1 | Target busy; stalls stepping in parallel mode |
| par_mode_i | input | 1 | 1: parallel byte mode, 0: serial bit mode |
| rev_sel_i | input | 2 | Revision select, sampled on a restart edge |
| data_o | output | 8 | Data value |
| data_oe_o | output | 8 | Per-bit output enable for data_o |
| clk_out_o | output | 1 | Step clock echo |
| clk_out_oe_o | output | 1 | Output enable for clk_out_o |
| por_drive_o | output | 1 | Power-on sequence holding the reset line low |

## Verification
A step or restart takes effect at the first rising clk_i edge that sees the stimulus. The counter, and data_o and data_oe_o with it, show the new value right after that edge. clk_out_o is high in the same cycle and low one cycle later. The driver changes inputs only on falling edges and pushes the expected outputs after that edge into the queue. The monitor compares them just after the next rising edge, and the driver has ensured that no tick is pending at that edge. During the internal-divider window, clk_out_o pulses are counted on falling edges. The address after the window is the start address plus that count.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  typedef enum logic {MODE_SERIAL = 1'b0, MODE_PARALLEL = 1'b1} out_mode_e;

  function automatic logic [7:0] rom_pattern(input int unsigned a);
    rom_pattern = 8'((a * 37 + 5) % 256);
  endfunction
endpackage

// File: rtl/cfgrd_step_gen.sv
module cfgrd_step_gen #(
  parameter int OSC_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_sel_i,
  input  logic cfg_clk_i,
  output logic tick_o
);
  localparam int CW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;

  logic [CW-1:0] div_q;
  logic          cfg_q;
  logic          osc_tick;

  assign osc_tick = (div_q == CW'(OSC_DIV - 1));
  assign tick_o   = clk_sel_i ? osc_tick : (cfg_clk_i & ~cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cfg_q <= 1'b0;
    end else begin
      cfg_q <= cfg_clk_i;
      div_q <= osc_tick ? '0 : div_q + 1'b1;
    end
  end

  // R9
  osc_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i && $past(clk_sel_i) && $past(tick_o)) |-> !tick_o);
endmodule

// File: rtl/cfgrd_por.sv
module cfgrd_por #(
  parameter int POR_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic por_busy_o
);
  localparam int PW = $clog2(POR_CYCLES + 1);

  logic [PW-1:0] cnt_q;

  assign por_busy_o = (cnt_q != PW'(POR_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (por_busy_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfgrd_addr_seq.sv
module cfgrd_addr_seq #(
  parameter int ADDR_W   = 6,
  parameter int REV_W    = 2,
  parameter int LEN_BASE = 4,
  parameter int LEN_INC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              standby_i,
  input  logic              hold_i,
  input  logic              restart_i,
  input  logic              busy_i,
  input  logic              par_i,
  input  logic [REV_W-1:0]  rev_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        bit_o,
  output logic              at_end_o
);
  localparam int REGION_W = ADDR_W - REV_W;

  function automatic logic [ADDR_W-1:0] base_of(input logic [REV_W-1:0] r);
    base_of = ADDR_W'(r) << REGION_W;
  endfunction

  function automatic logic [ADDR_W-1:0] end_of(input logic [REV_W-1:0] r);
    end_of = base_of(r) + ADDR_W'(LEN_BASE) + ADDR_W'(LEN_INC) * ADDR_W'(r);
  endfunction

  logic [REV_W-1:0]  rev_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        bit_q;
  logic              restart_q;
  logic              restart_rise;
  logic              can_step;

  assign restart_rise = restart_i & ~restart_q;
  assign at_end_o     = (addr_q == end_of(rev_q));
  assign can_step     = tick_i & restart_i & ~at_end_o & ~(par_i & busy_i);
  assign addr_o       = addr_q;
  assign bit_o        = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rev_q     <= '0;
      addr_q    <= '0;
      bit_q     <= '0;
      restart_q <= 1'b1;
    end else begin
      restart_q <= restart_i;
      if (standby_i || hold_i) begin
        addr_q <= base_of(rev_q);
        bit_q  <= '0;
      end else if (restart_rise) begin
        rev_q  <= rev_sel_i;
        addr_q <= base_of(rev_sel_i);
        bit_q  <= '0;
      end else if (can_step) begin
        if (par_i) begin
          addr_q <= addr_q + 1'b1;
          bit_q  <= '0;
        end else if (bit_q == 3'd7) begin
          addr_q <= addr_q + 1'b1;
          bit_q  <= '0;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  // R1
  step_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !standby_i && !hold_i) |=> ($stable(addr_q) && $stable(bit_q)));
  // R2
  hold_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_i || hold_i) |=> (addr_q == base_of(rev_q) && bit_q == 3'd0));
  // R4
  restart_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_rise && !standby_i && !hold_i) |=> (addr_q == base_of($past(rev_sel_i))));
  // R7
  end_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end_o && !restart_rise && !standby_i && !hold_i) |=> $stable(addr_q));
endmodule

// File: rtl/cfg_rom_reader.sv
module cfg_rom_reader #(
  parameter int ADDR_W     = 6,
  parameter int REV_W      = 2,
  parameter int DATA_W     = 8,
  parameter int LEN_BASE   = 4,
  parameter int LEN_INC    = 2,
  parameter int OSC_DIV    = 4,
  parameter int POR_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_clk_i,
  input  logic              clk_sel_i,
  input  logic              ce_ni_i,
  input  logic              oe_rst_ni_i,
  input  logic              restart_ni_i,
  input  logic              busy_i,
  input  logic              par_mode_i,
  input  logic [REV_W-1:0]  rev_sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic              clk_out_o,
  output logic              clk_out_oe_o,
  output logic              por_drive_o
);
  import cfgrd_pkg::*;

  logic              tick;
  logic              por_busy;
  logic              hold;
  logic              out_on;
  logic              data_on;
  logic              at_end;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        bit_idx;
  logic [DATA_W-1:0] cur_byte;
  logic              ser_bit;
  logic              clk_out_q;
  out_mode_e         mode;

  assign mode = out_mode_e'(par_mode_i);
  assign hold = ~oe_rst_ni_i | por_busy;

  cfgrd_step_gen #(.OSC_DIV(OSC_DIV)) u_step (
    .clk_i, .rst_ni, .clk_sel_i, .cfg_clk_i, .tick_o(tick)
  );

  cfgrd_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i, .rst_ni, .por_busy_o(por_busy)
  );

  cfgrd_addr_seq #(
    .ADDR_W(ADDR_W), .REV_W(REV_W), .LEN_BASE(LEN_BASE), .LEN_INC(LEN_INC)
  ) u_seq (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .standby_i (ce_ni_i),
    .hold_i    (hold),
    .restart_i (restart_ni_i),
    .busy_i,
    .par_i     (mode == MODE_PARALLEL),
    .rev_sel_i,
    .addr_o    (addr),
    .bit_o     (bit_idx),
    .at_end_o  (at_end)
  );

  assign cur_byte = rom_pattern(int'(addr));
  assign ser_bit  = cur_byte[3'd7 - bit_idx];
  assign out_on   = ~ce_ni_i & ~hold;
  assign data_on  = out_on & ~at_end;

  always_comb begin
    data_oe_o = '0;
    data_o    = '0;
    if (data_on) begin
      if (mode == MODE_PARALLEL) begin
        data_oe_o = '1;
        data_o    = cur_byte;
      end else begin
        data_oe_o[0] = 1'b1;
        data_o[0]    = ser_bit;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_out_q <= 1'b0;
    else         clk_out_q <= tick;
  end

  assign clk_out_o    = clk_out_q & out_on;
  assign clk_out_oe_o = out_on;
  assign por_drive_o  = por_busy;

  // R5
  serial_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SERIAL) |-> (data_oe_o[DATA_W-1:1] == '0));
  // R2
  hiz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_rst_ni_i |-> (data_oe_o == '0 && !clk_out_oe_o));
endmodule

// File: tb/cfg_rom_reader_tb_top.sv
module cfg_rom_reader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_clk = 1'b0, clk_sel = 1'b0, ce_n = 1'b0, oe_rst_n = 1'b1;
  logic restart_n = 1'b1, busy = 1'b0, par = 1'b1;
  logic [1:0] rev_sel = 2'd0;
  logic [7:0] data, data_oe;
  logic clk_out, clk_out_oe, por_drive;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {string tag; logic [7:0] oe; logic [7:0] d;} item_t;
  item_t sb_q[$];

  int exp_addr = 0, exp_bit = 0, exp_rev = 0;
  bit exp_on = 1;

  always #2ns clk = ~clk;

  cfg_rom_reader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_clk_i(cfg_clk), .clk_sel_i(clk_sel),
    .ce_ni_i(ce_n), .oe_rst_ni_i(oe_rst_n), .restart_ni_i(restart_n),
    .busy_i(busy), .par_mode_i(par), .rev_sel_i(rev_sel),
    .data_o(data), .data_oe_o(data_oe), .clk_out_o(clk_out),
    .clk_out_oe_o(clk_out_oe), .por_drive_o(por_drive)
  );

  function automatic logic [7:0] rom_b(int a); return 8'((a * 37 + 5) % 256); endfunction
  function automatic int rstart(int r); return r * 16; endfunction
  function automatic int rend(int r); return r * 16 + 4 + 2 * r; endfunction

  task automatic chk(string tag, logic ok, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  // driver: push the expected outputs; monitor compares after the next rising edge
  task automatic expect_out(string tag);
    item_t it;
    it.tag = tag;
    if (!exp_on || exp_addr == rend(exp_rev)) begin it.oe = 8'h00; it.d = 8'h00; end
    else if (par) begin it.oe = 8'hFF; it.d = rom_b(exp_addr); end
    else begin it.oe = 8'h01; it.d = {7'b0, rom_b(exp_addr)[7 - exp_bit]}; end
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1ns;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(it.tag, (data_oe == it.oe) && (data == it.d), {data_oe, data}, {it.oe, it.d});
    end
  end

  task automatic step(bit moves);
    @(negedge clk) cfg_clk = 1'b1;
    @(negedge clk) cfg_clk = 1'b0;
    if (moves && exp_addr != rend(exp_rev)) begin
      if (par || exp_bit == 7) begin exp_addr++; exp_bit = 0; end
      else exp_bit++;
    end
  endtask

  task automatic restart(int r);
    @(negedge clk) begin restart_n = 1'b0; rev_sel = 2'(r); end
    @(negedge clk) restart_n = 1'b1;
    @(negedge clk);
    exp_rev = r; exp_addr = rstart(r); exp_bit = 0;
  endtask

  initial begin
    #(4ns * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pcnt;
    int osc_cnt;
    repeat (3) @(negedge clk);
    // R8: power-on sequence
    rst_n = 1'b1;
    pcnt = 0;
    while (por_drive && pcnt < 50) begin
      if (pcnt == 0) chk("R8 por hiz", data_oe == 8'h00 && !clk_out_oe, {8'h0, data_oe}, 16'h0);
      pcnt++;
      @(negedge clk);
    end
    chk("R8 por length", pcnt == 8, 16'(pcnt), 16'd8);
    expect_out("R6 reset state rev0 byte0");

    // R6 parallel stream, R7 end of revision 0
    for (int i = 0; i < 4; i++) begin step(1); expect_out("R6 parallel step"); end
    step(1); expect_out("R7 stopped at end");

    // R4 restart to revision 2
    restart(2); expect_out("R4 restart rev2");
    // R1 restart low blocks stepping
    @(negedge clk) restart_n = 1'b0;
    step(0);
    restart_n = 1'b1;
    @(negedge clk);
    exp_addr = rstart(2); exp_bit = 0;
    expect_out("R1 restart low blocks step");
    // R1 busy stalls in parallel mode
    step(1); expect_out("R1 step rev2");
    busy = 1'b1; step(0); busy = 1'b0; expect_out("R1 busy stall parallel");

    // R10 clock echo
    @(negedge clk) cfg_clk = 1'b1;
    @(negedge clk) cfg_clk = 1'b0;
    chk("R10 clk_out pulse", clk_out == 1'b1 && clk_out_oe, {15'b0, clk_out}, 16'd1);
    @(negedge clk);
    chk("R10 clk_out low after", clk_out == 1'b0, {15'b0, clk_out}, 16'd0);
    exp_addr++;
    expect_out("R10 step via pulse");

    // R5 serial mode, revision 1, MSB first, busy ignored
    par = 1'b0;
    restart(1); expect_out("R5 serial first bit");
    busy = 1'b1;
    for (int i = 0; i < 8; i++) begin step(1); expect_out("R5 serial bit"); end
    busy = 1'b0;
    chk("R5 serial address moved", exp_addr == rstart(1) + 1, 16'(exp_addr), 16'(rstart(1) + 1));
    step(1); expect_out("R5 serial next byte bit");

    // R2 oe/reset low
    @(negedge clk) oe_rst_n = 1'b0;
    exp_on = 0; expect_out("R2 oe low hiz");
    chk("R2 clk_out_oe off", !clk_out_oe, {15'b0, clk_out_oe}, 16'd0);
    step(0); expect_out("R2 step ignored while held");
    oe_rst_n = 1'b1; exp_on = 1; exp_addr = rstart(1); exp_bit = 0;
    @(negedge clk); expect_out("R2 back to revision start");

    // R3 standby
    par = 1'b1;
    step(1); step(1); expect_out("R3 pre-standby");
    @(negedge clk) ce_n = 1'b1;
    exp_on = 0; expect_out("R3 standby hiz");
    chk("R3 clk_out_oe off", !clk_out_oe, {15'b0, clk_out_oe}, 16'd0);
    ce_n = 1'b0; exp_on = 1; exp_addr = rstart(1);
    @(negedge clk); expect_out("R3 counter reset after standby");

    // R9 internal divider, external edges ignored
    restart(3); expect_out("R9 rev3 start");
    clk_sel = 1'b1;
    osc_cnt = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      cfg_clk = ~cfg_clk;
      if (clk_out) osc_cnt++;
    end
    clk_sel = 1'b0; cfg_clk = 1'b0;
    @(negedge clk);
    chk("R9 osc tick count", osc_cnt == 8, 16'(osc_cnt), 16'd8);
    exp_addr = rstart(3) + osc_cnt;
    expect_out("R9 address after osc window");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule